// File: doc/BRIEF.md
# Linked-list DMA channel engine

This block moves data between memory locations for up to eight independent channels. Each channel holds a source address, a destination address, a link pointer, a control word and a configuration word, all programmed through a simple word-addressed register port. Once the engine is switched on, it walks the channels from the lowest index upward. It moves one element per service step through a 32-bit memory master port, and it stays on a channel for as long as that channel is still allowed to run.

Every step can be held back by peripheral request lines, depending on the flow type that the channel's configuration selects. When a channel's element count runs out, the engine does one of two things. If the link pointer is nonzero, it fetches a four-word descriptor from memory and carries on with the new block. If the link pointer is zero, it switches the channel off. A per-channel raw terminal-count flag records completions, and software clears it by writing ones.

Top module: `lldma_engine`

## Requirements
- R1: After reset every channel register, the global configuration word and the raw terminal-count flags read as zero, and no memory request is issued.
- R2: A channel is serviced only while global configuration bit 0 is set, its own configuration bit 0 is set and its configuration bit 18 (halt) is clear. Otherwise its count and the memory port do not change.
- R3: One element is a single read at the source address followed by a single write of that data to the destination address. The count in control bits 11:0 then drops by one, and control bits 31:12 keep their value.
- R4: Control bits 20:18 (source) and 23:21 (destination) give the element width as log2 of its byte count. The two must be equal and at most 2, or the channel is never serviced. `mem_size` carries this log2. Element data sits in the low bytes of the data buses, and the unused upper write bytes are zero.
- R5: Control bit 26 advances the source address and bit 27 advances the destination address by the element byte count after each element. A clear bit leaves that address fixed.
- R6: Configuration bits 13:11 select the flow type. 0 runs freely. 1 needs the request of the peripheral numbered in bits 10:6. 2 needs the request of the peripheral numbered in bits 5:1. 3 needs both. 4 to 7 never run. A request is the OR of `preq_single` and `preq_burst` at that index.
- R7: When the count reaches zero and the link pointer is nonzero, the engine reads the words at link+0, link+4, link+12 and link+8, in that order, into source, destination, control and link pointer. The channel then continues with the new block.
- R8: When a block completes, the channel's raw terminal-count flag is set if bit 31 of the control word held in the channel after completion handling is set, which after a reload is the newly loaded word. Word address 0x82 reads the flags, and writing ones to 0x81 clears them.
- R9: When the count reaches zero with a zero link pointer, configuration bit 0 of that channel is cleared.
- R10: Service starts at channel 0 whenever the global enable is off. The engine keeps serving a channel while it stays runnable and only then moves to the next index.
- R11: A memory request holds its address, direction and size until `mem_ready` is seen.
- R12: A configuration write while the engine is busy is accepted. An element already under way finishes, and the new setting governs the next scan step.
- R13: Channel c's registers sit at word address 8*c + {0 source, 1 destination, 2 link, 3 control, 4 configuration}, and the global configuration word sits at 0x80. All of these read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| preq_single | input | NREQ | Single-transfer peripheral requests |
| preq_burst | input | NREQ | Burst peripheral requests |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | log2 of access byte count |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory accepts/answers request this cycle |
| tc_raw | output | NCH | Raw terminal-count flags |

## Verification
Word, halfword and byte blocks, with every mix of fixed and advancing addresses and random memory latency, show whether the element width, the address steps and the count write-back are right. Flow types 1 to 3 are each driven first with only the wrong request line and then with the right one, which separates destination gating from source gating. Flow type 4 and a width mismatch show that illegal settings stay idle. Two descriptor chains differ only in which control word carries the interrupt-enable bit, so they show which word decides the flag. Two channels started together, and a halt written in the middle of a long block, exercise the scan order and a configuration change under way.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

   localparam logic [2:0] RSEL_SRC  = 3'd0;
   localparam logic [2:0] RSEL_DST  = 3'd1;
   localparam logic [2:0] RSEL_LINK = 3'd2;
   localparam logic [2:0] RSEL_CTRL = 3'd3;
   localparam logic [2:0] RSEL_CFG  = 3'd4;

   localparam int CFG_EN    = 0;
   localparam int CFG_HALT  = 18;
   localparam int CTRL_TCIE = 31;
   localparam int CTRL_DINC = 27;
   localparam int CTRL_SINC = 26;

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] link;
      logic [31:0] ctrl;
      logic [31:0] cfg;
   } chan_regs_t;

   typedef struct packed {
      logic        src_we;
      logic        dst_we;
      logic        link_we;
      logic        ctrl_we;
      logic        en_clr;
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] link;
      logic [31:0] ctrl;
   } chan_upd_t;

   typedef enum logic [1:0] {ST_SCAN, ST_READ, ST_WRITE, ST_LINK} eng_state_t;

   function automatic logic [31:0] lane_mask(input logic [1:0] szl);
      case (szl)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/lldma_chan_regs.sv
module lldma_chan_regs
   import lldma_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_we,
   input  logic [2:0] sw_sel,
   input  logic [31:0] sw_wdata,
   input  chan_upd_t  upd,
   output chan_regs_t regs
);

   // Software writes win over engine updates to the same register.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs <= '0;
      end else begin
         if (sw_we && sw_sel == RSEL_SRC)       regs.src <= sw_wdata;
         else if (upd.src_we)                   regs.src <= upd.src;

         if (sw_we && sw_sel == RSEL_DST)       regs.dst <= sw_wdata;
         else if (upd.dst_we)                   regs.dst <= upd.dst;

         if (sw_we && sw_sel == RSEL_LINK)      regs.link <= sw_wdata;
         else if (upd.link_we)                  regs.link <= upd.link;

         if (sw_we && sw_sel == RSEL_CTRL)      regs.ctrl <= sw_wdata;
         else if (upd.ctrl_we)                  regs.ctrl <= upd.ctrl;

         if (sw_we && sw_sel == RSEL_CFG)       regs.cfg <= sw_wdata;
         else if (upd.en_clr)                   regs.cfg[CFG_EN] <= 1'b0;
      end
   end

endmodule

// File: rtl/lldma_gate.sv
module lldma_gate
   import lldma_pkg::*;
#(
   parameter int NREQ = 32
) (
   input  chan_regs_t      regs,
   input  logic            glob_en,
   input  logic [NREQ-1:0] req_any,
   output logic            go
);

   logic [31:0] req32;
   logic [2:0]  flow;
   logic [4:0]  src_pid;
   logic [4:0]  dst_pid;
   logic [2:0]  swl;
   logic [2:0]  dwl;
   logic        width_ok;
   logic        flow_ok;
   logic        armed;

   assign req32    = 32'(req_any);
   assign flow     = regs.cfg[13:11];
   assign src_pid  = regs.cfg[5:1];
   assign dst_pid  = regs.cfg[10:6];
   assign swl      = regs.ctrl[20:18];
   assign dwl      = regs.ctrl[23:21];
   assign width_ok = (swl == dwl) && (swl <= 3'd2);
   assign armed    = glob_en && regs.cfg[CFG_EN] && !regs.cfg[CFG_HALT];

   always_comb begin
      case (flow)
         3'd0:    flow_ok = 1'b1;
         3'd1:    flow_ok = req32[dst_pid];
         3'd2:    flow_ok = req32[src_pid];
         3'd3:    flow_ok = req32[src_pid] && req32[dst_pid];
         default: flow_ok = 1'b0;
      endcase
   end

   assign go = armed && width_ok && flow_ok && (regs.ctrl[11:0] != 12'd0);

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
   import lldma_pkg::*;
#(
   parameter int NCH = 8,
   localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   glob_en,
   input  logic [NCH-1:0]         go,
   input  chan_regs_t [NCH-1:0]   regs_all,
   output chan_upd_t  [NCH-1:0]   upd_all,
   output logic [NCH-1:0]         tc_set,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [31:0]            mem_addr,
   output logic [1:0]             mem_size,
   output logic [31:0]            mem_wdata,
   input  logic [31:0]            mem_rdata,
   input  logic                   mem_ready
);

   eng_state_t     state;
   logic [CIW-1:0] cur;
   logic [1:0]     lidx;
   logic [31:0]    data_q;

   chan_regs_t  r;
   logic [1:0]  szl;
   logic [31:0] step;
   logic [11:0] cnt_nxt;
   logic [31:0] link_off;
   logic        last_elem;
   chan_upd_t   u;
   logic        tc_hit;

   assign r         = regs_all[cur];
   assign szl       = r.ctrl[19:18];
   assign step      = 32'd1 << szl;
   assign cnt_nxt   = r.ctrl[11:0] - 12'd1;
   assign last_elem = (cnt_nxt == 12'd0);

   // Descriptor word order: source, destination, control, then link last.
   always_comb begin
      case (lidx)
         2'd0:    link_off = 32'd0;
         2'd1:    link_off = 32'd4;
         2'd2:    link_off = 32'd12;
         default: link_off = 32'd8;
      endcase
   end

   assign mem_req   = (state != ST_SCAN);
   assign mem_we    = (state == ST_WRITE);
   assign mem_wdata = data_q;
   assign mem_size  = (state == ST_LINK) ? 2'd2 : szl;

   always_comb begin
      case (state)
         ST_READ:  mem_addr = r.src;
         ST_WRITE: mem_addr = r.dst;
         ST_LINK:  mem_addr = r.link + link_off;
         default:  mem_addr = '0;
      endcase
   end

   always_comb begin
      u      = '0;
      tc_hit = 1'b0;
      if (state == ST_WRITE && mem_ready) begin
         u.src_we  = r.ctrl[CTRL_SINC];
         u.src     = r.src + step;
         u.dst_we  = r.ctrl[CTRL_DINC];
         u.dst     = r.dst + step;
         u.ctrl_we = 1'b1;
         u.ctrl    = {r.ctrl[31:12], cnt_nxt};
         if (last_elem && r.link == 32'd0) begin
            u.en_clr = 1'b1;
            tc_hit   = r.ctrl[CTRL_TCIE];
         end
      end else if (state == ST_LINK && mem_ready) begin
         case (lidx)
            2'd0: begin u.src_we  = 1'b1; u.src  = mem_rdata; end
            2'd1: begin u.dst_we  = 1'b1; u.dst  = mem_rdata; end
            2'd2: begin u.ctrl_we = 1'b1; u.ctrl = mem_rdata; end
            default: begin
               u.link_we = 1'b1;
               u.link    = mem_rdata;
               tc_hit    = r.ctrl[CTRL_TCIE];
            end
         endcase
      end
   end

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         upd_all[i] = (CIW'(i) == cur) ? u : '0;
         tc_set[i]  = (CIW'(i) == cur) && tc_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_SCAN;
         cur    <= '0;
         lidx   <= '0;
         data_q <= '0;
      end else begin
         case (state)
            ST_SCAN: begin
               if (!glob_en)                 cur <= '0;
               else if (go[cur])             state <= ST_READ;
               else if (cur == CIW'(NCH-1))  cur <= '0;
               else                          cur <= cur + 1'b1;
            end
            ST_READ: begin
               if (mem_ready) begin
                  data_q <= mem_rdata & lane_mask(szl);
                  state  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_ready) begin
                  lidx  <= '0;
                  state <= (last_elem && r.link != 32'd0) ? ST_LINK : ST_SCAN;
               end
            end
            default: begin
               if (mem_ready) begin
                  lidx <= lidx + 2'd1;
                  if (lidx == 2'd3) state <= ST_SCAN;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
   import lldma_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int NREQ = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [7:0]      reg_waddr,
   input  logic [31:0]     reg_wdata,
   input  logic [7:0]      reg_raddr,
   output logic [31:0]     reg_rdata,
   input  logic [NREQ-1:0] preq_single,
   input  logic [NREQ-1:0] preq_burst,
   output logic            mem_req,
   output logic            mem_we,
   output logic [31:0]     mem_addr,
   output logic [1:0]      mem_size,
   output logic [31:0]     mem_wdata,
   input  logic [31:0]     mem_rdata,
   input  logic            mem_ready,
   output logic [NCH-1:0]  tc_raw
);

   localparam logic [7:0] A_GCFG  = 8'h80;
   localparam logic [7:0] A_TCCLR = 8'h81;
   localparam logic [7:0] A_TCRAW = 8'h82;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("lldma_engine: NCH must lie in 1..8");
   end
   if (NREQ < 1 || NREQ > 32) begin : g_bad_nreq
      $error("lldma_engine: NREQ must lie in 1..32");
   end

   logic [31:0]          glob_cfg;
   logic                 glob_en;
   logic [NREQ-1:0]      req_any;
   logic                 wr_chan;
   chan_regs_t [NCH-1:0] regs_all;
   chan_upd_t  [NCH-1:0] upd_all;
   logic [NCH-1:0]       go;
   logic [NCH-1:0]       tc_set;
   logic [NCH-1:0]       tc_clr;

   assign glob_en = glob_cfg[0];
   assign req_any = preq_single | preq_burst;
   assign wr_chan = reg_we && (reg_waddr[7:6] == 2'b00);
   assign tc_clr  = (reg_we && reg_waddr == A_TCCLR) ? reg_wdata[NCH-1:0] : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      lldma_chan_regs u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .sw_we    (wr_chan && reg_waddr[5:3] == 3'(i)),
         .sw_sel   (reg_waddr[2:0]),
         .sw_wdata (reg_wdata),
         .upd      (upd_all[i]),
         .regs     (regs_all[i])
      );
      lldma_gate #(.NREQ(NREQ)) u_gate (
         .regs    (regs_all[i]),
         .glob_en (glob_en),
         .req_any (req_any),
         .go      (go[i])
      );
   end

   lldma_seq #(.NCH(NCH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .glob_en   (glob_en),
      .go        (go),
      .regs_all  (regs_all),
      .upd_all   (upd_all),
      .tc_set    (tc_set),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready)
   );

   // A completion in the same cycle as a clear keeps the flag set.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_cfg <= '0;
         tc_raw   <= '0;
      end else begin
         if (reg_we && reg_waddr == A_GCFG) glob_cfg <= reg_wdata;
         tc_raw <= (tc_raw & ~tc_clr) | tc_set;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_raddr == A_GCFG) begin
         reg_rdata = glob_cfg;
      end else if (reg_raddr == A_TCRAW) begin
         reg_rdata = 32'(tc_raw);
      end else if (reg_raddr[7:6] == 2'b00) begin
         for (int i = 0; i < NCH; i++) begin
            if (reg_raddr[5:3] == 3'(i)) begin
               case (reg_raddr[2:0])
                  RSEL_SRC:  reg_rdata = regs_all[i].src;
                  RSEL_DST:  reg_rdata = regs_all[i].dst;
                  RSEL_LINK: reg_rdata = regs_all[i].link;
                  RSEL_CTRL: reg_rdata = regs_all[i].ctrl;
                  RSEL_CFG:  reg_rdata = regs_all[i].cfg;
                  default:   reg_rdata = '0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/lldma_checker.sv
module lldma_checker #(
   parameter int NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           glob_en,
   input logic           mem_req,
   input logic           mem_we,
   input logic           mem_ready,
   input logic [31:0]    mem_addr,
   input logic [1:0]     mem_size,
   input logic [31:0]    mem_wdata,
   input logic [NCH-1:0] tc_raw
);

   AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)); // R11

   AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(glob_en)); // R2

   AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_size <= 2'd2); // R4

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_size == 2'd0 |-> mem_wdata[31:8] == 24'd0); // R4

   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_req && mem_ready && !mem_we)); // R3

   AST_TC_FROM_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
      (|(tc_raw & ~$past(tc_raw))) |-> $past(mem_req && mem_ready)); // R8

endmodule

bind lldma_engine lldma_checker #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .glob_en   (glob_en),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_size  (mem_size),
   .mem_wdata (mem_wdata),
   .tc_raw    (tc_raw)
);

// File: tb/lldma_engine_test.sv
module lldma_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 8;
   localparam int NREQ = 32;

   logic            clk;
   logic            rst_n;
   logic            reg_we;
   logic [7:0]      reg_waddr;
   logic [31:0]     reg_wdata;
   logic [7:0]      reg_raddr;
   logic [31:0]     reg_rdata;
   logic [NREQ-1:0] preq_single;
   logic [NREQ-1:0] preq_burst;
   logic            mem_req;
   logic            mem_we;
   logic [31:0]     mem_addr;
   logic [1:0]      mem_size;
   logic [31:0]     mem_wdata;
   logic [31:0]     mem_rdata;
   logic            mem_ready;
   logic [NCH-1:0]  tc_raw;

   lldma_engine #(.NCH(NCH), .NREQ(NREQ)) uut (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .preq_single(preq_single), .preq_burst(preq_burst),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .tc_raw(tc_raw)
   );

   logic [7:0] mem_b [0:1023];
   logic [7:0] ref_b [0:1023];
   int n_chk = 0;
   int n_err = 0;
   int hs_cnt = 0;
   int wr_seq = 0;
   int ch0_last = -1;
   int ch1_first = -1;
   int wait_q = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // Memory model, answers with random latency at the falling edge.
   initial begin
      mem_ready = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_req && wait_q == 0) begin
            logic [9:0] a;
            a = mem_addr[9:0];
            mem_ready = 1'b1;
            mem_rdata = {mem_b[10'(a+3)], mem_b[10'(a+2)], mem_b[10'(a+1)], mem_b[a]};
            if (mem_we) begin
               for (int k = 0; k < (1 << mem_size); k++) mem_b[10'(a+k)] = mem_wdata[8*k +: 8];
               if (a >= 10'h300 && a < 10'h340) ch0_last = wr_seq;
               if (a >= 10'h380 && a < 10'h3C0 && ch1_first < 0) ch1_first = wr_seq;
               wr_seq++;
            end
            hs_cnt++;
            wait_q = $urandom % 3;
         end else begin
            mem_ready = 1'b0;
            if (mem_req && wait_q > 0) wait_q--;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [7:0] caddr(input int ch, input int sel);
      return 8'(ch * 8 + sel);
   endfunction

   function automatic logic [31:0] mk_ctrl(input int tcie, input int di, input int si,
                                           input int szl, input int cnt);
      return (32'(tcie) << 31) | (32'(di) << 27) | (32'(si) << 26) |
             (32'(szl) << 21) | (32'(szl) << 18) | 32'(cnt);
   endfunction

   task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] l, input logic [31:0] c, input logic [31:0] g);
      reg_wr(caddr(ch, 0), s);
      reg_wr(caddr(ch, 1), d);
      reg_wr(caddr(ch, 2), l);
      reg_wr(caddr(ch, 3), c);
      reg_wr(caddr(ch, 4), g);
   endtask

   task automatic wait_idle(input int ch);
      logic [31:0] v;
      for (int i = 0; i < 4000; i++) begin
         reg_rd(caddr(ch, 4), v);
         if (!v[0]) break;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic sync_ref();
      for (int i = 0; i < 1024; i++) ref_b[i] = mem_b[i];
   endtask

   task automatic ref_copy(input int s, input int d, input int cnt, input int szl,
                           input int si, input int di);
      for (int e = 0; e < cnt; e++) begin
         for (int k = 0; k < (1 << szl); k++) ref_b[(d + k) & 1023] = ref_b[(s + k) & 1023];
         if (si != 0) s += (1 << szl);
         if (di != 0) d += (1 << szl);
      end
   endtask

   function automatic int mem_diff();
      int n = 0;
      for (int i = 0; i < 1024; i++) if (mem_b[i] !== ref_b[i]) n++;
      return n;
   endfunction

   task automatic put_word(input int a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) mem_b[a + k] = w[8*k +: 8];
   endtask

   initial begin
      logic [31:0] v, v2;
      int hs0;
      void'($urandom(32'd7341));
      rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
      preq_single = '0; preq_burst = '0;
      for (int i = 0; i < 1024; i++) mem_b[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      v2 = '0;
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < 5; s++) begin reg_rd(caddr(c, s), v); v2 |= v; end
      chk("R1 channel regs zero", v2, 32'd0);
      reg_rd(8'h80, v);
      chk("R1 global cfg zero", v, 32'd0);
      chk("R1 tc flags zero", 32'(tc_raw), 32'd0);
      chk("R1 no mem request", 32'(mem_req), 32'd0);

      // R13: register map readback
      reg_wr(caddr(3, 2), 32'hABCD_0010);
      reg_rd(caddr(3, 2), v);
      chk("R13 link readback", v, 32'hABCD_0010);
      reg_wr(caddr(3, 2), 32'd0);

      // R2: global off and halt bit block service
      sync_ref();
      hs0 = hs_cnt;
      prog(0, 32'h000, 32'h200, 32'd0, mk_ctrl(1, 1, 1, 2, 4), 32'h1);
      repeat (30) @(negedge clk);
      reg_rd(caddr(0, 3), v);
      chk("R2 global off count", 32'(v[11:0]), 32'd4);
      chk("R2 global off no traffic", 32'(hs_cnt - hs0), 32'd0);
      reg_wr(caddr(0, 4), 32'h1 | (32'h1 << 18));
      reg_wr(8'h80, 32'h1);
      repeat (30) @(negedge clk);
      reg_rd(caddr(0, 3), v);
      chk("R2 halt count", 32'(v[11:0]), 32'd4);
      hs0 = hs_cnt;
      reg_wr(caddr(0, 4), 32'h1);
      wait_idle(0);
      ref_copy(32'h000, 32'h200, 4, 2, 1, 1);
      chk("R3 word copy memory", 32'(mem_diff()), 32'd0);
      chk("R11 handshakes per block", 32'(hs_cnt - hs0), 32'd8);
      reg_rd(caddr(0, 3), v);
      chk("R3 ctrl write-back", v, mk_ctrl(1, 1, 1, 2, 0));
      reg_rd(caddr(0, 0), v);
      chk("R5 source advanced", v, 32'h010);
      reg_rd(caddr(0, 1), v);
      chk("R5 destination advanced", v, 32'h210);
      reg_rd(caddr(0, 4), v);
      chk("R9 enable cleared", v, 32'h0);
      chk("R8 tc flag set", 32'(tc_raw), 32'h1);
      reg_wr(8'h81, 32'hFF);
      reg_rd(8'h82, v);
      chk("R8 tc cleared", v, 32'h0);

      // R4: byte elements, fixed destination
      sync_ref();
      prog(2, 32'h020, 32'h2F0, 32'd0, mk_ctrl(0, 0, 1, 0, 5), 32'h1);
      wait_idle(2);
      ref_copy(32'h020, 32'h2F0, 5, 0, 1, 0);
      chk("R4 byte copy memory", 32'(mem_diff()), 32'd0);
      reg_rd(caddr(2, 1), v);
      chk("R5 fixed destination", v, 32'h2F0);
      reg_rd(caddr(2, 0), v);
      chk("R5 byte source step", v, 32'h025);
      chk("R8 no tc without enable bit", 32'(tc_raw), 32'h0);

      // R4: halfword elements
      sync_ref();
      prog(2, 32'h030, 32'h2A0, 32'd0, mk_ctrl(0, 1, 1, 1, 3), 32'h1);
      wait_idle(2);
      ref_copy(32'h030, 32'h2A0, 3, 1, 1, 1);
      chk("R4 halfword copy memory", 32'(mem_diff()), 32'd0);
      reg_rd(caddr(2, 0), v);
      chk("R5 halfword source step", v, 32'h036);

      // R4: width mismatch never runs
      prog(2, 32'h030, 32'h2A0, 32'd0, (32'd2 << 18) | (32'd1 << 21) | 32'd3, 32'h1);
      repeat (30) @(negedge clk);
      reg_rd(caddr(2, 3), v);
      chk("R4 width mismatch idle", 32'(v[11:0]), 32'd3);
      reg_wr(caddr(2, 4), 32'h0);

      // R6: flow type 1 gated by destination peripheral 5
      sync_ref();
      prog(1, 32'h060, 32'h240, 32'd0, mk_ctrl(0, 1, 1, 2, 2),
           32'h1 | (32'd1 << 11) | (32'd5 << 6));
      repeat (30) @(negedge clk);
      reg_rd(caddr(1, 3), v);
      chk("R6 flow1 waits", 32'(v[11:0]), 32'd2);
      preq_burst[5] = 1'b1;
      wait_idle(1);
      preq_burst = '0;
      ref_copy(32'h060, 32'h240, 2, 2, 1, 1);
      chk("R6 flow1 runs on burst request", 32'(mem_diff()), 32'd0);

      // R6: flow type 2 gated by source peripheral 3
      sync_ref();
      prog(1, 32'h070, 32'h250, 32'd0, mk_ctrl(0, 1, 1, 2, 2),
           32'h1 | (32'd2 << 11) | (32'd3 << 1) | (32'd9 << 6));
      preq_single[9] = 1'b1;
      repeat (30) @(negedge clk);
      reg_rd(caddr(1, 3), v);
      chk("R6 flow2 ignores destination request", 32'(v[11:0]), 32'd2);
      preq_single[3] = 1'b1;
      wait_idle(1);
      preq_single = '0;
      ref_copy(32'h070, 32'h250, 2, 2, 1, 1);
      chk("R6 flow2 runs on single request", 32'(mem_diff()), 32'd0);

      // R6: flow type 3 needs both
      sync_ref();
      prog(1, 32'h080, 32'h260, 32'd0, mk_ctrl(0, 1, 1, 2, 2),
           32'h1 | (32'd3 << 11) | (32'd7 << 1) | (32'd9 << 6));
      preq_single[7] = 1'b1;
      repeat (30) @(negedge clk);
      reg_rd(caddr(1, 3), v);
      chk("R6 flow3 needs both", 32'(v[11:0]), 32'd2);
      preq_burst[9] = 1'b1;
      wait_idle(1);
      preq_single = '0; preq_burst = '0;
      ref_copy(32'h080, 32'h260, 2, 2, 1, 1);
      chk("R6 flow3 runs with both", 32'(mem_diff()), 32'd0);

      // R6: flow type 4 unsupported
      preq_single = '1; preq_burst = '1;
      prog(1, 32'h080, 32'h260, 32'd0, mk_ctrl(0, 1, 1, 2, 2), 32'h1 | (32'd4 << 11));
      repeat (30) @(negedge clk);
      reg_rd(caddr(1, 3), v);
      chk("R6 flow4 never runs", 32'(v[11:0]), 32'd2);
      reg_wr(caddr(1, 4), 32'h0);
      preq_single = '0; preq_burst = '0;

      // R7/R8: reload with tc enable only in loaded word
      put_word(32'h380, 32'h040);
      put_word(32'h384, 32'h2C0);
      put_word(32'h388, 32'h0);
      put_word(32'h38C, mk_ctrl(1, 1, 1, 2, 3));
      sync_ref();
      prog(4, 32'h000, 32'h280, 32'h380, mk_ctrl(0, 1, 1, 2, 2), 32'h1);
      wait_idle(4);
      ref_copy(32'h000, 32'h280, 2, 2, 1, 1);
      ref_copy(32'h040, 32'h2C0, 3, 2, 1, 1);
      chk("R7 chained copy memory", 32'(mem_diff()), 32'd0);
      reg_rd(caddr(4, 2), v);
      chk("R7 link reloaded", v, 32'h0);
      reg_rd(caddr(4, 0), v);
      chk("R7 source reloaded", v, 32'h04C);
      reg_rd(caddr(4, 1), v);
      chk("R7 destination reloaded", v, 32'h2CC);
      chk("R8 tc from loaded word", 32'(tc_raw), 32'h10);
      reg_wr(8'h81, 32'hFF);

      // R8: tc enable only in the first word, cleared by reload
      put_word(32'h3A0, 32'h050);
      put_word(32'h3A4, 32'h2E0);
      put_word(32'h3A8, 32'h0);
      put_word(32'h3AC, mk_ctrl(0, 1, 1, 2, 1));
      prog(4, 32'h010, 32'h2D0, 32'h3A0, mk_ctrl(1, 1, 1, 2, 1), 32'h1);
      wait_idle(4);
      chk("R8 tc follows reloaded word", 32'(tc_raw), 32'h0);
      reg_rd(caddr(4, 3), v);
      chk("R7 ctrl from descriptor", v, mk_ctrl(0, 1, 1, 2, 0));

      // R10: scan order from channel 0
      reg_wr(8'h80, 32'h0);
      sync_ref();
      prog(1, 32'h140, 32'h380, 32'd0, mk_ctrl(0, 1, 1, 2, 8), 32'h1);
      prog(0, 32'h100, 32'h300, 32'd0, mk_ctrl(0, 1, 1, 2, 8), 32'h1);
      ch0_last = -1; ch1_first = -1;
      reg_wr(8'h80, 32'h1);
      wait_idle(0);
      wait_idle(1);
      ref_copy(32'h100, 32'h300, 8, 2, 1, 1);
      ref_copy(32'h140, 32'h380, 8, 2, 1, 1);
      chk("R10 both copies", 32'(mem_diff()), 32'd0);
      chk("R10 channel 0 finished before channel 1",
          32'((ch0_last >= 0) && (ch1_first > ch0_last)), 32'd1);

      // R12: halt written mid-block
      prog(5, 32'h3F0, 32'h3F8, 32'd0, mk_ctrl(0, 0, 0, 2, 200), 32'h1);
      repeat (40) @(negedge clk);
      reg_wr(caddr(5, 4), 32'h1 | (32'h1 << 18));
      repeat (10) @(negedge clk);
      reg_rd(caddr(5, 3), v);
      repeat (40) @(negedge clk);
      reg_rd(caddr(5, 3), v2);
      chk("R12 halt freezes count", v2, v);
      chk("R12 halted mid-block", 32'((v[11:0] > 0) && (v[11:0] < 200)), 32'd1);
      reg_wr(caddr(5, 4), 32'h1);
      wait_idle(5);
      reg_rd(caddr(5, 3), v);
      chk("R12 resumes to zero", 32'(v[11:0]), 32'd0);

      // Random blocks: R3 R4 R5
      for (int it = 0; it < 8; it++) begin
         int ch, szl, cnt, si, di, s, d;
         ch  = $urandom % NCH;
         szl = $urandom % 3;
         cnt = 1 + $urandom % 8;
         si  = $urandom % 2;
         di  = $urandom % 2;
         s   = ($urandom % 32) * 4;
         d   = 32'h200 + ($urandom % 32) * 4;
         sync_ref();
         prog(ch, 32'(s), 32'(d), 32'd0, mk_ctrl(0, di, si, szl, cnt), 32'h1);
         wait_idle(ch);
         ref_copy(s, d, cnt, szl, si, di);
         chk("R3 random copy memory", 32'(mem_diff()), 32'd0);
         reg_rd(caddr(ch, 0), v);
         chk("R5 random source", v, 32'(s + ((si != 0) ? cnt << szl : 0)));
      end

      finish_run();
   end

endmodule